// File: doc/BRIEF.md
# Register write-lock controller

This block guards a small bank of registers against late or stray software writes. It holds one 32-bit lock word made of sticky enable bits. Each enable bit opens or closes the write path to one protected register. The four protected registers are the lock word itself, a status register, a control register and a time-trim register. Software clears an enable bit to close that path. After that, no write can reopen the path, and only a reset restores it.

The block decodes a simple single-cycle bus with an address, a write strobe, write data and combinational read data. It also holds plain 32-bit stand-ins for the status, control and trim registers, so that the effect of each lock can be seen through ordinary reads. There are two synchronous, active-high reset inputs. The power-on reset reopens every path. The software reset reopens every path except the one guarding the control register. The power-on reset wins when both are asserted.

Top module: `wlock_guard`

## Requirements
- R1: After power-on reset, reading the lock word returns 0x000000FF.
- R2: In the lock word, bits 31..8 always read 0, and bit 7 and bits 2..0 always read 1, whatever value was written to them.
- R3: A permitted write to the lock word sets each enable bit to (current value AND written bit). A 0 written to an enable bit clears it, and a 1 written to an enable bit that is already 0 leaves it at 0. The enable bit positions are: bit 6 for the lock word, bit 5 for status, bit 4 for control and bit 3 for trim. A value of 1 means open.
- R4: A write to a protected register whose enable bit is 1 stores the write data, and a read in the following cycle returns that data.
- R5: A write to a protected register whose enable bit is 0 is ignored, and the register keeps its contents.
- R6: While bit 6 of the lock word is 0, writes to the lock word are ignored, so all the enable bits are frozen.
- R7: A software reset sets bits 6, 5 and 3 to 1 and leaves bit 4 (the control enable) at its current value.
- R8: A power-on reset sets all four enable bits to 1, including bit 4. It takes priority when the software reset is asserted in the same cycle.
- R9: Either reset clears the status, control and trim stand-ins to 0.
- R10: A write to an address outside the four mapped registers changes nothing, and a read from such an address returns 0.
- R11: Reads are never blocked by a lock. Read data reflects the addressed register in the same cycle that the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high, has priority |
| sw_rst | input | 1 | Synchronous software reset, active high |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench builds the block with ADDR_W=8, MAP_BASE=0x40 and STRIDE=4, so the registers sit at 0x40, 0x44, 0x48 and 0x4C. This placement leaves unmapped addresses both below and above the window, and a misaligned address (0x42) inside it. All three are probed, so the equality decode is exercised on every side. With these values the bench can also step through clearing the control enable, surviving a software reset with it, freezing the lock word through its own bit, and finally reopening everything with both resets asserted together.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

  localparam int DATA_W   = 32;
  localparam int NREG     = 4;
  // register indices; each also selects its enable bit (position LK_TOP - index)
  localparam int REG_LOCK = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_TRIM = 3;
  localparam int LK_TOP   = 6;

  // enable bits that a software reset leaves untouched
  localparam logic [NREG-1:0] SW_KEEP = 4'b0100;
  // fixed read image of the lock word with all enable positions at 0
  localparam logic [DATA_W-1:0] LOCK_FIXED = 32'h0000_0087;

  typedef logic [NREG-1:0] lock_vec_t;

  function automatic int lk_pos(input int r);
    return LK_TOP - r;
  endfunction

  // gather the enable field out of a bus word
  function automatic lock_vec_t lock_field(input logic [DATA_W-1:0] w);
    lock_vec_t f;
    for (int r = 0; r < NREG; r++) f[r] = w[lk_pos(r)];
    return f;
  endfunction

  // sticky clear: a bit can only go from 1 to 0 by a write
  function automatic lock_vec_t lock_merge(input lock_vec_t old,
                                           input logic [DATA_W-1:0] w);
    return old & lock_field(w);
  endfunction

  // software reset: reopen all bits except the kept ones
  function automatic lock_vec_t lock_soft(input lock_vec_t q);
    return q | ~SW_KEEP;
  endfunction

  // bus read image of the lock word
  function automatic logic [DATA_W-1:0] lock_image(input lock_vec_t q);
    logic [DATA_W-1:0] img;
    img = LOCK_FIXED;
    for (int r = 0; r < NREG; r++) img[lk_pos(r)] = q[r];
    return img;
  endfunction

endpackage

// File: rtl/wlock_decode.sv
module wlock_decode
  import wlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MAP_BASE = 0,
  parameter int STRIDE   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic [NREG-1:0]   sel,
  output logic [NREG-1:0]   wr_req,
  output logic              hit
);

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      sel[r] = (addr == ADDR_W'(MAP_BASE + r * STRIDE));
    end
    wr_req = sel & {NREG{we}};
    hit    = |sel;
  end

endmodule

// File: rtl/wlock_bits.sv
module wlock_bits
  import wlock_pkg::*;
(
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sw_rst,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output lock_vec_t         lk_q
);

  logic lock_upd;
  assign lock_upd = wr_lock && lk_q[REG_LOCK];

  always_ff @(posedge clk) begin
    if (por_rst)       lk_q <= '1;
    else if (sw_rst)   lk_q <= lock_soft(lk_q);
    else if (lock_upd) lk_q <= lock_merge(lk_q, wdata);
  end

  AST_LOCK_NO_SET: assert property (@(posedge clk) disable iff (por_rst)
    !sw_rst |=> ((lk_q & ~$past(lk_q)) == '0)); // R3

  AST_SELF_FREEZE: assert property (@(posedge clk) disable iff (por_rst)
    (!sw_rst && !lk_q[REG_LOCK]) |=> $stable(lk_q)); // R6

  AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (por_rst)
    sw_rst |=> (lk_q[REG_CTRL] == $past(lk_q[REG_CTRL])) && lk_q[REG_LOCK]
               && lk_q[REG_STAT] && lk_q[REG_TRIM]); // R7

  AST_POR_OPEN: assert property (@(posedge clk)
    por_rst |=> (lk_q == '1)); // R8

endmodule

// File: rtl/wlock_shadow.sv
module wlock_shadow
  import wlock_pkg::*;
(
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sw_rst,
  input  logic              wr_req,
  input  logic              grant,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic commit;
  assign commit = wr_req && grant;

  always_ff @(posedge clk) begin
    if (por_rst || sw_rst) q <= '0;
    else if (commit)       q <= wdata;
  end

  AST_PASS_WRITE: assert property (@(posedge clk) disable iff (por_rst || sw_rst)
    (wr_req && grant) |=> (q == $past(wdata))); // R4

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (por_rst || sw_rst)
    (wr_req && !grant) |=> $stable(q)); // R5

  AST_RST_CLEAR: assert property (@(posedge clk)
    (por_rst || sw_rst) |=> (q == '0)); // R9

endmodule

// File: rtl/wlock_guard.sv
module wlock_guard
  import wlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MAP_BASE = 0,
  parameter int STRIDE   = 4
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [NREG-1:0]   sel;
  logic [NREG-1:0]   wr_req;
  logic              hit;
  lock_vec_t         lk_q;
  logic [DATA_W-1:0] stand_q [1:NREG-1];

  wlock_decode #(.ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .STRIDE(STRIDE)) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .sel    (sel),
    .wr_req (wr_req),
    .hit    (hit)
  );

  wlock_bits u_bits (
    .clk     (clk),
    .por_rst (por_rst),
    .sw_rst  (sw_rst),
    .wr_lock (wr_req[REG_LOCK]),
    .wdata   (bus_wdata),
    .lk_q    (lk_q)
  );

  for (genvar r = 1; r < NREG; r++) begin : g_stand
    wlock_shadow u_sh (
      .clk     (clk),
      .por_rst (por_rst),
      .sw_rst  (sw_rst),
      .wr_req  (wr_req[r]),
      .grant   (lk_q[r]),
      .wdata   (bus_wdata),
      .q       (stand_q[r])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      for (int r = 1; r < NREG; r++) begin
        if (sel[r]) bus_rdata = stand_q[r];
      end
      if (sel[REG_LOCK]) bus_rdata = lock_image(lk_q);
    end
  end

  AST_RSV_READ: assert property (@(posedge clk) disable iff (por_rst)
    sel[REG_LOCK] |-> (bus_rdata[31:8] == '0) && bus_rdata[7]
                      && (bus_rdata[2:0] == 3'b111)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (por_rst)
    !hit |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/wlock_guard_tb.sv
module wlock_guard_tb_top;

  localparam int ADDR_W = 8;
  localparam logic [7:0] A_LOCK = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_CTRL = 8'h48;
  localparam logic [7:0] A_TRIM = 8'h4C;

  logic              clk = 1'b0;
  logic              por_rst = 1'b1;
  logic              sw_rst = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;

  always #5 clk = ~clk;

  wlock_guard #(.ADDR_W(ADDR_W), .MAP_BASE(8'h40), .STRIDE(4)) dut_i (
    .clk(clk), .por_rst(por_rst), .sw_rst(sw_rst), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model: enable bits [0]=lock word, [1]=status, [2]=control, [3]=trim
  logic [3:0]  m_lk;
  logic [31:0] m_st [1:3];

  function automatic logic [31:0] lock_word_exp(input logic [3:0] lk);
    return {24'h0, 1'b1, lk[0], lk[1], lk[2], lk[3], 3'b111};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_LOCK:  return lock_word_exp(m_lk);
      A_STAT:  return m_st[1];
      A_CTRL:  return m_st[2];
      A_TRIM:  return m_st[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    if (a == A_LOCK) begin
      if (m_lk[0]) m_lk = m_lk & {d[3], d[4], d[5], d[6]};
    end else if (a == A_STAT && m_lk[1]) m_st[1] = d;
    else if (a == A_CTRL && m_lk[2]) m_st[2] = d;
    else if (a == A_TRIM && m_lk[3]) m_st[3] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    it.exp = model_read(a); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_reset(input logic p, input logic s);
    @(negedge clk);
    bus_we = 1'b0; por_rst = p; sw_rst = s;
    if (p) m_lk = 4'hF;
    else if (s) m_lk = m_lk | 4'b1011;
    for (int i = 1; i <= 3; i++) m_st[i] = 32'h0;
    @(negedge clk);
    por_rst = 1'b0; sw_rst = 1'b0;
  endtask

  // monitor: compare read data with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        sb_item_t it;
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, bus_addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_lk = 4'hF;
    for (int i = 1; i <= 3; i++) m_st[i] = 32'h0;
    repeat (2) @(negedge clk);
    por_rst = 1'b0;
    do_read(A_LOCK, "R1");
    do_read(A_STAT, "R9");
    do_read(A_CTRL, "R9");
    // open writes land (R4)
    do_write(A_STAT, 32'h0000_1234);
    do_read(A_STAT, "R4");
    do_write(A_CTRL, 32'hCAFE_0001);
    do_read(A_CTRL, "R4");
    do_write(A_TRIM, 32'h0000_00A5);
    do_read(A_TRIM, "R4");
    // clear status enable, reserved bits written with 0 (R2, R3)
    do_write(A_LOCK, 32'h0000_0058);
    do_read(A_LOCK, "R2");
    do_write(A_STAT, 32'h0000_AAAA);
    do_read(A_STAT, "R5");  // locked register still readable: R11
    // writing 1 does not reopen (R3), reserved 1s in high bits still read 0 (R2)
    do_write(A_LOCK, 32'hFFFF_FFFF);
    do_read(A_LOCK, "R3");
    // software reset reopens status, clears stand-ins (R7, R9)
    do_reset(1'b0, 1'b1);
    do_read(A_LOCK, "R7");
    do_read(A_TRIM, "R9");
    // close control, then survive a software reset (R7)
    do_write(A_LOCK, 32'h0000_00EF);
    do_read(A_LOCK, "R3");
    do_write(A_CTRL, 32'h0000_0055);
    do_read(A_CTRL, "R5");
    do_reset(1'b0, 1'b1);
    do_read(A_LOCK, "R7");
    do_write(A_CTRL, 32'h0000_0066);
    do_read(A_CTRL, "R5");
    // self-lock freezes the word (R6)
    do_write(A_LOCK, 32'h0000_00BF);
    do_read(A_LOCK, "R6");
    do_write(A_LOCK, 32'h0000_0000);
    do_read(A_LOCK, "R6");
    do_write(A_TRIM, 32'h0000_0077);
    do_read(A_TRIM, "R4");
    // unmapped addresses below, above and misaligned (R10)
    do_write(8'h50, 32'hDEAD_BEEF);
    do_read(8'h50, "R10");
    do_write(8'h42, 32'h1111_1111);
    do_read(8'h42, "R10");
    do_write(8'h00, 32'h2222_2222);
    do_read(8'h00, "R10");
    do_read(A_TRIM, "R10");
    do_read(A_STAT, "R10");
    // both resets together: power-on wins (R8)
    do_reset(1'b1, 1'b1);
    do_read(A_LOCK, "R8");
    do_read(A_TRIM, "R9");
    @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule